// File: doc/BRIEF.md
# Stack-Relative Shifted Subtract Unit

This block computes the stack-pointer value minus a second operand that first passes through an immediate-controlled shifter. The shift kind is one of left logical, right logical, right arithmetic, or rotate right. The immediate field is interpreted modulo the word width. A zero immediate therefore selects a full-width right shift or a one-bit rotate through the carry flag. The difference is formed as an addition of the inverted operand with a carry-in of one, and the negative, zero, carry and overflow flags come from that addition.

A small routing stage decides what the result is used for. It may be written to a general register, or it may be presented as a branch target or an exception-return target when the destination index names the program counter. In the compact encoding form, a program-counter destination with flag setting acts as a compare. The same form flags forbidden operand combinations on an error output. The flags are held in a register that is loaded on a clock edge when an accepted operation asks for it. The surrounding pipeline supplies `op_valid` once per operation and takes the combinational result and strobes in the same cycle.

Top module: `spsub_unit`

## Requirements
- R1: `shift_type` codes are 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. With `shift_imm` from 1 to 31, the operand is shifted or rotated by that many bits.
- R2: Left logical with `shift_imm` 0 passes `rm_val` through unchanged.
- R3: With `shift_imm` 0, right logical yields zero, which is a 32-bit shift. Right arithmetic yields 32 copies of bit 31.
- R4: Rotate right with `shift_imm` 0 rotates by one bit, and `carry_in` enters bit 31.
- R5: `result` equals `base_val` plus the bitwise inverse of the shifted operand plus one, modulo 2^32.
- R6: The computed flags are N = result bit 31, Z = result is zero, C = carry-out of the addition (1 means no borrow), and V = signed overflow of the subtraction. `nzcv_next` and `nzcv_q` pack them as {N,Z,C,V} in bits [3:0].
- R7: `nzcv_q` resets to 0000. On a rising edge it loads the computed flags only when a flag update is permitted by R8–R11. Otherwise it holds. `nzcv_next` shows the value it will hold after the edge.
- R8: Wide form (`compact_form`=0), destination 15, `set_flags`=0: `pc_branch`=1 and `reg_we`=0. A destination other than 15 gives `reg_we`=1, and flags update only if `set_flags`=1.
- R9: Wide form, destination 15, `set_flags`=1: `exc_return`=1, `reg_we`=0, and the flags do not change.
- R10: Compact form, destination 15, `set_flags`=1: a compare. The flags update, and `reg_we`, `pc_branch` and `exc_return` stay 0.
- R11: Compact form with destination 15 and `set_flags`=0, or with `rm_idx`=15: `enc_error`=1, and no register write, no strobe and no flag update.
- R12: With `op_valid`=0, every strobe, `reg_we` and `enc_error` are 0 and `nzcv_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| compact_form | input | 1 | 1 selects the compact encoding rules |
| base_val | input | 32 | Stack pointer value |
| rm_val | input | 32 | Second operand before shifting |
| rm_idx | input | 4 | Register index of the second operand |
| shift_type | input | 2 | Shift kind code |
| shift_imm | input | 5 | Shift amount modulo 32 |
| carry_in | input | 1 | Current carry flag, used by the one-bit rotate |
| set_flags | input | 1 | Operation asks for a flag update |
| dest_idx | input | 4 | Destination register index |
| result | output | 32 | Difference |
| nzcv_next | output | 4 | Flag value after this cycle's edge |
| nzcv_q | output | 4 | Registered flags |
| reg_we | output | 1 | Write result to register `dest_idx` |
| pc_branch | output | 1 | Result is a branch target |
| exc_return | output | 1 | Result is an exception-return target |
| enc_error | output | 1 | Forbidden encoding in compact form |

## Verification
Every cycle, the assertions confirm that the register-write enable and the two program-counter strobes are never active together. They also confirm that an encoding error or an idle cycle suppresses every side effect, and that an exception return never coincides with a flag load. The flag register is checked on each edge to either hold or load the value previously shown on `nzcv_next`. The shifter's zero-amount left pass-through and the adder's carry-as-no-borrow relation are checked combinationally. Only the bench scenarios show the numeric correctness of each shift kind at chosen amounts, the rotate-through-carry fill, the overflow cases at the signed limits, and the full routing table, since these need a model built independently of the datapath.

// File: rtl/spsub_pkg.sv
// Shared types for the stack-relative shifted subtract unit.
// Assumes a two-bit shift kind code fixed by the instruction encoding.
package spsub_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/spsub_shifter.sv
// Immediate-controlled shifter for the second operand.
// Decodes a zero amount as a full-width right shift (LSR/ASR), a
// one-bit rotate through carry (ROR) or a pass-through (LSL).
// Assumes SH_W = clog2(DATA_W) and that amounts wrap modulo DATA_W.
module spsub_shifter
    import spsub_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] sh_in,
    input  shift_kind_e       sh_kind,
    input  logic [SH_W-1:0]   sh_amt,
    input  logic              sh_cin,
    output logic [DATA_W-1:0] sh_out
);

    localparam logic [SH_W:0] WIDTH_EXT = (SH_W+1)'(DATA_W);

    logic              amt_zero;
    logic [SH_W:0]     rot_back;
    logic [DATA_W-1:0] asr_val;

    // Decode helpers: zero amount and complementary rotate distance.
    always_comb begin
        amt_zero = (sh_amt == '0);
        rot_back = WIDTH_EXT - {1'b0, sh_amt};
        asr_val  = $unsigned($signed(sh_in) >>> sh_amt);
    end

    // Select the shifted operand by kind, applying the zero-amount rules.
    always_comb begin
        unique case (sh_kind)
            SHK_LSL: sh_out = sh_in << sh_amt;
            SHK_LSR: sh_out = amt_zero ? '0 : (sh_in >> sh_amt);
            SHK_ASR: sh_out = amt_zero ? {DATA_W{sh_in[DATA_W-1]}} : asr_val;
            default: sh_out = amt_zero ? {sh_cin, sh_in[DATA_W-1:1]}
                                       : ((sh_in >> sh_amt) | (sh_in << rot_back));
        endcase
    end

    // R2
    always_comb begin
        if (sh_kind == SHK_LSL && amt_zero) begin
            lsl_zero_chk: assert (sh_out == sh_in);
        end
    end

endmodule

// File: rtl/spsub_adder.sv
// Subtractor built as base + ~operand + 1, producing the four flags.
// Assumes unsigned carry-out semantics: carry set means no borrow.
module spsub_adder
    import spsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] add_a,
    input  logic [DATA_W-1:0] add_b,
    output logic [DATA_W-1:0] add_res,
    output flags_t            add_flags
);

    logic [DATA_W-1:0] b_inv;
    logic [DATA_W:0]   sum_ext;

    // Invert the subtrahend and add with a carry-in of one.
    always_comb begin
        b_inv   = ~add_b;
        sum_ext = {1'b0, add_a} + {1'b0, b_inv} + (DATA_W+1)'(1);
        add_res = sum_ext[DATA_W-1:0];
    end

    // Derive sign, zero, carry-out and signed overflow from the sum.
    always_comb begin
        add_flags.n = sum_ext[DATA_W-1];
        add_flags.z = (sum_ext[DATA_W-1:0] == '0);
        add_flags.c = sum_ext[DATA_W];
        add_flags.v = (add_a[DATA_W-1] == b_inv[DATA_W-1]) &&
                      (sum_ext[DATA_W-1] != add_a[DATA_W-1]);
    end

    // R6
    always_comb begin
        carry_borrow_chk: assert (add_flags.c == (add_a >= add_b));
    end

endmodule

// File: rtl/spsub_route.sv
// Destination routing: register write, branch, exception return,
// compare and forbidden-encoding detection. Clock and reset serve the
// assertions only. Assumes the program counter is the highest index.
module spsub_route #(
    parameter int IDX_W = 4,
    localparam logic [IDX_W-1:0] PC_IDX = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rt_valid,
    input  logic             rt_compact,
    input  logic             rt_setf,
    input  logic [IDX_W-1:0] rt_dest,
    input  logic [IDX_W-1:0] rt_rm,
    output logic             rt_reg_we,
    output logic             rt_branch,
    output logic             rt_exc_ret,
    output logic             rt_flag_we,
    output logic             rt_error
);

    logic dest_pc, rm_pc, forbidden, accept;

    // Classify the operation against the encoding rules.
    always_comb begin
        dest_pc   = (rt_dest == PC_IDX);
        rm_pc     = (rt_rm == PC_IDX);
        forbidden = rt_compact && ((dest_pc && !rt_setf) || rm_pc);
        accept    = rt_valid && !forbidden;
    end

    // Drive the side-effect strobes from the classification.
    always_comb begin
        rt_error   = rt_valid && forbidden;
        rt_reg_we  = accept && !dest_pc;
        rt_branch  = accept && dest_pc && !rt_setf && !rt_compact;
        rt_exc_ret = accept && dest_pc && rt_setf && !rt_compact;
        rt_flag_we = accept && rt_setf && (!dest_pc || rt_compact);
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rt_reg_we, rt_branch, rt_exc_ret}));

    // R11
    error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_error |-> !rt_reg_we && !rt_branch && !rt_exc_ret && !rt_flag_we);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_valid |-> !rt_reg_we && !rt_branch && !rt_exc_ret && !rt_flag_we && !rt_error);

    // R9
    exc_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_exc_ret |-> rt_setf && (rt_dest == PC_IDX) && !rt_flag_we);

endmodule

// File: rtl/spsub_unit.sv
// Top of the stack-relative shifted subtract unit: shifter, adder,
// routing and the registered flag state. The datapath is combinational;
// only the flags are stored. Synchronous active-low reset.
module spsub_unit
    import spsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              compact_form,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [IDX_W-1:0]  rm_idx,
    input  logic [1:0]        shift_type,
    input  logic [SH_W-1:0]   shift_imm,
    input  logic              carry_in,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        nzcv_next,
    output logic [3:0]        nzcv_q,
    output logic              reg_we,
    output logic              pc_branch,
    output logic              exc_return,
    output logic              enc_error
);

    logic [DATA_W-1:0] shifted;
    flags_t            calc_flags;
    flags_t            flags_r;
    logic              flag_we;

    spsub_shifter #(.DATA_W(DATA_W)) u_shift (
        .sh_in  (rm_val),
        .sh_kind(shift_kind_e'(shift_type)),
        .sh_amt (shift_imm),
        .sh_cin (carry_in),
        .sh_out (shifted)
    );

    spsub_adder #(.DATA_W(DATA_W)) u_add (
        .add_a    (base_val),
        .add_b    (shifted),
        .add_res  (result),
        .add_flags(calc_flags)
    );

    spsub_route #(.IDX_W(IDX_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .rt_valid  (op_valid),
        .rt_compact(compact_form),
        .rt_setf   (set_flags),
        .rt_dest   (dest_idx),
        .rt_rm     (rm_idx),
        .rt_reg_we (reg_we),
        .rt_branch (pc_branch),
        .rt_exc_ret(exc_return),
        .rt_flag_we(flag_we),
        .rt_error  (enc_error)
    );

    // Flag register: load computed flags when routing permits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_r <= '0;
        end else if (flag_we) begin
            flags_r <= calc_flags;
        end
    end

    // Present registered and next-state flags.
    always_comb begin
        nzcv_q    = flags_r;
        nzcv_next = flag_we ? calc_flags : flags_r;
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> nzcv_q == $past(nzcv_q));

    // R7
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> nzcv_q == $past(nzcv_next));

endmodule

// File: tb/tb_spsub_unit.sv
module tb_spsub_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        compact_form = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] rm_val = '0;
    logic [3:0]  rm_idx = '0;
    logic [1:0]  shift_type = '0;
    logic [4:0]  shift_imm = '0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [3:0]  dest_idx = '0;
    logic [31:0] result;
    logic [3:0]  nzcv_next, nzcv_q;
    logic        reg_we, pc_branch, exc_return, enc_error;

    spsub_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  nx;
        logic [3:0]  q;
        logic        we, br, er, err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          tests = 0;
    int          fails = 0;
    logic [3:0]  model_q = 4'b0000;
    bit          done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] shift_model(logic [31:0] x, int typ, int amt, logic cin);
        int n;
        n = (amt == 0) ? 32 : amt;
        case (typ)
            0: return (amt == 0) ? x : 32'(64'(x) << amt);
            1: return 32'({32'h0, x} >> n);
            2: return 32'({{32{x[31]}}, x} >> n);
            default: return (amt == 0) ? 32'({cin, x} >> 1) : 32'({x, x} >> amt);
        endcase
    endfunction

    // Driver: apply one operation at a falling edge and push its expectation.
    task automatic op(string tag, bit cf, logic [31:0] b, logic [31:0] m, int mi,
                      int typ, int imm, bit cin, bit s, int d, bit v = 1);
        exp_t        e;
        logic [31:0] sh, r;
        longint      sd;
        logic [3:0]  f;
        bit          bad, upd;
        @(negedge clk);
        op_valid = v; compact_form = cf; base_val = b; rm_val = m; rm_idx = 4'(mi);
        shift_type = 2'(typ); shift_imm = 5'(imm); carry_in = cin;
        set_flags = s; dest_idx = 4'(d);
        sh = shift_model(m, typ, imm, cin);
        r  = b - sh;
        sd = longint'($signed(b)) - longint'($signed(sh));
        f  = {r[31], r == 0, b >= sh, (sd > 64'sd2147483647) || (sd < -64'sd2147483648)};
        bad = cf && ((d == 15 && !s) || mi == 15);
        e.res = r;
        e.err = v && bad;
        e.we  = v && !bad && d != 15;
        e.br  = v && !bad && !cf && d == 15 && !s;
        e.er  = v && !bad && !cf && d == 15 && s;
        upd   = v && !bad && s && (d != 15 || cf);
        e.q   = model_q;
        e.nx  = upd ? f : model_q;
        e.tag = tag;
        sb.push_back(e);
        if (upd) model_q = f;
    endtask

    // Monitor: pop one expectation per cycle and compare away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.we || e.br || e.er || (e.nx != e.q)) chk(e.tag, "result", result, e.res);
                chk(e.tag, "nzcv_next", 32'(nzcv_next), 32'(e.nx));
                chk(e.tag, "nzcv_q", 32'(nzcv_q), 32'(e.q));
                chk(e.tag, "strobes", {28'h0, reg_we, pc_branch, exc_return, enc_error},
                    {28'h0, e.we, e.br, e.er, e.err});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "reset nzcv_q", 32'(nzcv_q), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 each kind with nonzero amounts
        op("R1", 0, 32'h0000_1000, 32'h0000_0010, 2, 0, 4, 0, 1, 1);
        op("R1", 0, 32'h8000_0000, 32'hF000_0F00, 3, 1, 8, 0, 1, 2);
        op("R1", 0, 32'h1234_5678, 32'h8000_0040, 3, 2, 4, 0, 1, 2);
        op("R1", 0, 32'h0000_0000, 32'h0000_00AB, 3, 3, 8, 1, 1, 2);
        op("R1", 0, 32'h7FFF_FFFF, 32'hDEAD_BEEF, 4, 3, 31, 0, 1, 5);
        // R2 left pass-through
        op("R2", 0, 32'h0000_0100, 32'h0000_0100, 4, 0, 0, 1, 1, 6);
        // R3 zero-amount right shifts
        op("R3", 0, 32'h0000_0005, 32'h8000_0000, 4, 1, 0, 0, 1, 6);
        op("R3", 0, 32'h0000_0005, 32'h8000_0000, 4, 2, 0, 0, 1, 6);
        op("R3", 0, 32'h0000_0005, 32'h7000_0000, 4, 2, 0, 0, 1, 6);
        // R4 rotate through carry
        op("R4", 0, 32'h0000_0000, 32'h0000_0003, 4, 3, 0, 1, 1, 7);
        op("R4", 0, 32'hFFFF_FFFF, 32'h0000_0003, 4, 3, 0, 0, 1, 7);
        // R5 R6 flags at limits
        op("R6", 0, 32'h0000_0000, 32'h0000_0001, 1, 0, 0, 0, 1, 3);
        op("R6", 0, 32'h8000_0000, 32'h0000_0001, 1, 0, 0, 0, 1, 3);
        op("R6", 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 3);
        op("R5", 0, 32'hABCD_0000, 32'hABCD_0000, 1, 0, 0, 0, 1, 3);
        // R7 no set_flags: flags hold
        op("R7", 0, 32'h0000_0001, 32'h0000_0009, 1, 0, 0, 0, 0, 3);
        // R8 branch, R9 exception return
        op("R8", 0, 32'h0000_2000, 32'h0000_0004, 1, 0, 2, 0, 0, 15);
        op("R9", 0, 32'h0000_0000, 32'h0000_0004, 1, 0, 0, 0, 1, 15);
        // R10 compare in compact form
        op("R10", 1, 32'h0000_0010, 32'h0000_0020, 1, 0, 0, 0, 1, 15);
        // R11 forbidden compact encodings
        op("R11", 1, 32'h0000_0010, 32'h0000_0010, 1, 0, 0, 0, 0, 15);
        op("R11", 1, 32'h0000_0010, 32'h0000_0010, 15, 0, 0, 0, 1, 2);
        // Wide form allows rm index 15
        op("R8", 0, 32'h0000_0030, 32'h0000_0010, 15, 0, 0, 0, 1, 2);
        // R12 idle cycle with flag-setting fields
        op("R12", 0, 32'h0000_0000, 32'h0000_0000, 1, 0, 0, 0, 1, 2, 0);
        op("R12", 0, 32'h0000_0000, 32'h0000_0001, 1, 0, 0, 0, 1, 15, 0);
        op("R7", 0, 32'h0000_0000, 32'h0000_0000, 1, 0, 0, 0, 0, 1, 0);
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule